// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves blocks of words between I/O ports and memory so that the processor does not have to. Each of four channels is set up by the processor with a direction, a device port number, a starting memory address and a word count, and is then enabled. The controller asks for the shared system bus. Once it is granted, it uses one bus cycle to move one word. In that cycle it drives the memory address, the port address and a complementary pair of strobes. The data travels straight from the source to the sink and is never held inside the block. The controller then lets go of the bus and asks again for the next word.

When a channel's count runs out, the channel disables itself and sets its done flag. Done flags that are not masked off raise an interrupt. When more than one channel is waiting, the lowest-numbered one wins. This choice is made again at every word boundary, and only one channel uses the bus at a time. A channel's registers accept writes only while the channel is disabled.

Top module: `flyby_dma_ctrl`

## Requirements
- R1: After reset all channels are disabled with done clear, and `bus_req_o`, all strobes and `irq_o` are low.
- R2: The register index on `cfg_reg_i` selects the register: 0 is control, 1 is port address, 2 is memory address, 3 is count. The control bits are: bit0 enable, bit1 direction (1 = port-to-memory), bit2 interrupt mask (1 = allowed), bit3 done on read. `cfg_rdata_o` returns the addressed register in the same cycle.
- R3: Any write to a channel that is currently enabled is ignored, including a write that tries to clear its enable bit.
- R4: The bus request rises the cycle after a channel becomes pending. Addresses and strobes are driven only in the single cycle after a grant is sampled, and are zero otherwise. The request drops after that word cycle.
- R5: In port-to-memory mode `port_rd_o` and `mem_wr_o` pulse together. In memory-to-port mode `mem_rd_o` and `port_wr_o` pulse together. Never both pairs at once.
- R6: After each word the channel's memory address goes up by one and its count goes down by one.
- R7: One cycle after an enabled channel's count is zero, its enable clears and its done bit sets. Enabling a channel with count zero completes it with no bus activity.
- R8: `irq_o` is high exactly when some channel has both done and mask set.
- R9: Writing control with bit3 = 1 to a disabled channel clears its done bit.
- R10: At each word boundary the lowest-numbered pending channel is picked, so a lower channel enabled mid-block takes over at the next word.
- R11: `xfer_ch_o` names the single channel driving the current word cycle and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | 2 | Channel being accessed |
| cfg_reg_i | input | 2 | Register index within the channel |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data of the addressed register |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| mem_addr_o | output | 16 | Memory address during the word cycle |
| port_addr_o | output | 8 | Device port during the word cycle |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| port_rd_o | output | 1 | Port read strobe |
| port_wr_o | output | 1 | Port write strobe |
| xfer_ch_o | output | 2 | Channel in the current word cycle |
| chan_en_o | output | 4 | Per-channel enable state |
| chan_done_o | output | 4 | Per-channel done flags |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench goes after these corner cases:
- A grant that is held back for several cycles. A design that strobes on the request rather than on the grant would drive the bus early.
- A write that tries to disable or reprogram a live channel. A design that accepts it would corrupt a block mid-transfer or strand it.
- A lower channel enabled while a higher one is mid-block. A design that holds on to the current channel would break the fixed priority.
- A zero-count enable. A design that transfers anyway would run off by one word and wrap the count.
- A done flag on a masked channel. A design that ignores the mask would raise a spurious interrupt.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} xfer_state_e;

  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_PORT = 2'd1;
  localparam logic [1:0] REG_MEM  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_DIR  = 1;
  localparam int unsigned CTL_MASK = 2;
  localparam int unsigned CTL_DONE = 3;
endpackage

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
  import flyby_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        wr_reg_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              step_i,
  output logic              en_o,
  output logic              dir_o,
  output logic              mask_o,
  output logic              done_o,
  output logic [PORT_W-1:0] port_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pend_o
);
  logic              en_q, dir_q, mask_q, done_q;
  logic [PORT_W-1:0] port_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      mask_q  <= 1'b0;
      done_q  <= 1'b0;
      port_q  <= '0;
      maddr_q <= '0;
      cnt_q   <= '0;
    end else if (en_q) begin
      // live channel: programming locked out
      if (cnt_q == '0) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end else if (step_i) begin
        maddr_q <= maddr_q + 1'b1;
        cnt_q   <= cnt_q - 1'b1;
      end
    end else if (wr_i) begin
      case (wr_reg_i)
        REG_CTL: begin
          en_q   <= wdata_i[CTL_EN];
          dir_q  <= wdata_i[CTL_DIR];
          mask_q <= wdata_i[CTL_MASK];
          if (wdata_i[CTL_DONE]) done_q <= 1'b0;
        end
        REG_PORT: port_q  <= wdata_i[PORT_W-1:0];
        REG_MEM:  maddr_q <= wdata_i[ADDR_W-1:0];
        default:  cnt_q   <= wdata_i[CNT_W-1:0];
      endcase
    end
  end

  assign en_o    = en_q;
  assign dir_o   = dir_q;
  assign mask_o  = mask_q;
  assign done_o  = done_q;
  assign port_o  = port_q;
  assign maddr_o = maddr_q;
  assign cnt_o   = cnt_q;
  assign pend_o  = en_q && (cnt_q != '0);
endmodule

// File: rtl/flyby_dma_prio.sv
module flyby_dma_prio #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = CH_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/flyby_dma_fsm.sv
module flyby_dma_fsm
  import flyby_dma_pkg::*;
#(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            any_i,
  input  logic [CH_W-1:0] idx_i,
  input  logic            gnt_i,
  output logic            req_o,
  output logic            xfer_o,
  output logic [CH_W-1:0] sel_o
);
  xfer_state_e     state_q;
  logic [CH_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (any_i) begin
          sel_q   <= idx_i;
          state_q <= ST_REQ;
        end
        ST_REQ:  if (gnt_i) state_q <= ST_XFER;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q != ST_IDLE);
  assign xfer_o = (state_q == ST_XFER);
  assign sel_o  = sel_q;
endmodule

// File: rtl/flyby_dma_ctrl.sv
module flyby_dma_ctrl
  import flyby_dma_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REG_W  = 16,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [1:0]        cfg_reg_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PORT_W-1:0] port_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              port_rd_o,
  output logic              port_wr_o,
  output logic [CH_W-1:0]   xfer_ch_o,
  output logic [NUM_CH-1:0] chan_en_o,
  output logic [NUM_CH-1:0] chan_done_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] en, dir, mask, done, pend;
  logic [PORT_W-1:0] port  [NUM_CH];
  logic [ADDR_W-1:0] maddr [NUM_CH];
  logic [CNT_W-1:0]  cnt   [NUM_CH];
  logic              any_pend, xfer;
  logic [CH_W-1:0]   win_idx, sel;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    flyby_dma_chan #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .CNT_W(CNT_W), .REG_W(REG_W)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_we_i && (cfg_ch_i == CH_W'(g))),
      .wr_reg_i(cfg_reg_i),
      .wdata_i (cfg_wdata_i),
      .step_i  (xfer && (sel == CH_W'(g))),
      .en_o    (en[g]),
      .dir_o   (dir[g]),
      .mask_o  (mask[g]),
      .done_o  (done[g]),
      .port_o  (port[g]),
      .maddr_o (maddr[g]),
      .cnt_o   (cnt[g]),
      .pend_o  (pend[g])
    );
  end

  flyby_dma_prio #(.NUM_CH(NUM_CH)) u_prio (
    .pend_i(pend),
    .any_o (any_pend),
    .idx_o (win_idx)
  );

  flyby_dma_fsm #(.CH_W(CH_W)) u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .any_i (any_pend),
    .idx_i (win_idx),
    .gnt_i (bus_gnt_i),
    .req_o (bus_req_o),
    .xfer_o(xfer),
    .sel_o (sel)
  );

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_reg_i)
      REG_CTL: begin
        cfg_rdata_o[CTL_EN]   = en[cfg_ch_i];
        cfg_rdata_o[CTL_DIR]  = dir[cfg_ch_i];
        cfg_rdata_o[CTL_MASK] = mask[cfg_ch_i];
        cfg_rdata_o[CTL_DONE] = done[cfg_ch_i];
      end
      REG_PORT: cfg_rdata_o[PORT_W-1:0] = port[cfg_ch_i];
      REG_MEM:  cfg_rdata_o[ADDR_W-1:0] = maddr[cfg_ch_i];
      default:  cfg_rdata_o[CNT_W-1:0]  = cnt[cfg_ch_i];
    endcase
  end

  // fly-by: only addresses and strobes leave the block
  assign mem_addr_o  = xfer ? maddr[sel] : '0;
  assign port_addr_o = xfer ? port[sel]  : '0;
  assign mem_wr_o    = xfer &  dir[sel];
  assign port_rd_o   = xfer &  dir[sel];
  assign mem_rd_o    = xfer & ~dir[sel];
  assign port_wr_o   = xfer & ~dir[sel];
  assign xfer_ch_o   = xfer ? sel : '0;
  assign chan_en_o   = en;
  assign chan_done_o = done;
  assign irq_o       = |(done & mask);
endmodule

// File: rtl/flyby_dma_ctrl_chk.sv
module flyby_dma_ctrl_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              port_rd_o,
  input logic              port_wr_o,
  input logic [NUM_CH-1:0] chan_en_o,
  input logic [NUM_CH-1:0] chan_done_o
);
  logic word_cyc;
  assign word_cyc = mem_rd_o | mem_wr_o;

  AST_STROBE_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cyc |-> $past(bus_req_o && bus_gnt_i)); // R4
  AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cyc |=> !bus_req_o); // R4
  AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_cyc |-> (mem_addr_o == '0)); // R4
  AST_STROBE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o == port_rd_o) && (mem_rd_o == port_wr_o) && !(mem_rd_o && mem_wr_o)); // R5
  AST_DONE_ON_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chan_done_o & ~$past(chan_done_o)) & ~($past(chan_en_o) & ~chan_en_o)) == '0); // R7
endmodule

bind flyby_dma_ctrl flyby_dma_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .port_rd_o  (port_rd_o),
  .port_wr_o  (port_wr_o),
  .chan_en_o  (chan_en_o),
  .chan_done_o(chan_done_o)
);

// File: tb/flyby_dma_ctrl_test.sv
module flyby_dma_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  ch = '0;
  logic [1:0]  rg = '0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic        req, gnt = 1'b0;
  logic [15:0] maddr_o;
  logic [7:0]  paddr_o;
  logic        mrd, mwr, prd, pwr, irq;
  logic [1:0]  xch;
  logic [3:0]  en_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int gnt_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  // reference model state
  int m_en[4], m_dir[4], m_mask[4], m_done[4], m_port[4], m_maddr[4], m_cnt[4];
  int m_state = 0, m_sel = 0;

  always #4 clk = ~clk;

  flyby_dma_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_ch_i(ch), .cfg_reg_i(rg),
    .cfg_wdata_i(wd), .cfg_rdata_o(rd), .bus_req_o(req), .bus_gnt_i(gnt),
    .mem_addr_o(maddr_o), .port_addr_o(paddr_o), .mem_rd_o(mrd), .mem_wr_o(mwr),
    .port_rd_o(prd), .port_wr_o(pwr), .xfer_ch_o(xch), .chan_en_o(en_o),
    .chan_done_o(done_o), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // model: advances on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_en[c] = 0; m_dir[c] = 0; m_mask[c] = 0; m_done[c] = 0;
        m_port[c] = 0; m_maddr[c] = 0; m_cnt[c] = 0;
      end
      m_state = 0; m_sel = 0;
    end else begin
      int old_en[4];
      int win, st, sl;
      win = -1; st = m_state; sl = m_sel;
      for (int c = 3; c >= 0; c--) begin
        old_en[c] = m_en[c];
        if (m_en[c] != 0 && m_cnt[c] != 0) win = c;
      end
      for (int c = 0; c < 4; c++) begin
        if (old_en[c] != 0 && m_cnt[c] == 0) begin
          m_en[c] = 0; m_done[c] = 1;
        end else if (old_en[c] != 0 && st == 2 && sl == c) begin
          m_maddr[c] = (m_maddr[c] + 1) & 16'hFFFF;
          m_cnt[c]   = m_cnt[c] - 1;
        end
      end
      if (we && old_en[ch] == 0) begin
        case (rg)
          2'd0: begin
            m_en[ch] = wd[0]; m_dir[ch] = wd[1]; m_mask[ch] = wd[2];
            if (wd[3]) m_done[ch] = 0;
          end
          2'd1: m_port[ch]  = wd[7:0];
          2'd2: m_maddr[ch] = wd;
          default: m_cnt[ch] = wd;
        endcase
      end
      case (st)
        0: if (win >= 0) begin m_sel = win; m_state = 1; end
        1: if (gnt) m_state = 2;
        default: m_state = 0;
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit x;
      int e_en, e_done, e_irq;
      x = (m_state == 2);
      e_en = 0; e_done = 0; e_irq = 0;
      for (int c = 0; c < 4; c++) begin
        e_en   |= m_en[c] << c;
        e_done |= m_done[c] << c;
        if (m_done[c] != 0 && m_mask[c] != 0) e_irq = 1;
      end
      chk(req == (m_state != 0), "R4 bus_req", req, m_state != 0);
      chk(mwr == (x && m_dir[m_sel] != 0) && prd == mwr, "R5 port->mem strobes", {prd, mwr}, x && m_dir[m_sel] != 0);
      chk(mrd == (x && m_dir[m_sel] == 0) && pwr == mrd, "R5 mem->port strobes", {pwr, mrd}, x && m_dir[m_sel] == 0);
      chk(maddr_o == (x ? m_maddr[m_sel] : 0), "R6 mem_addr", maddr_o, x ? m_maddr[m_sel] : 0);
      chk(paddr_o == (x ? m_port[m_sel] : 0), "R4 port_addr", paddr_o, x ? m_port[m_sel] : 0);
      chk(xch == (x ? m_sel : 0), "R11 xfer_ch", xch, x ? m_sel : 0);
      chk(en_o == e_en, "R7 chan_en", en_o, e_en);
      chk(done_o == e_done, "R7 chan_done", done_o, e_done);
      chk(irq == e_irq, "R8 irq", irq, e_irq);
    end
  end

  // grant source: always, or pseudo-random
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    gnt  <= (gnt_mode == 0) ? 1'b1 : (lfsr[1] & lfsr[4]);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr(input int c, input int r, input int d);
    @(negedge clk);
    we = 1'b1; ch = 2'(c); rg = 2'(r); wd = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input int c, input int r, input int exp, input string tag);
    @(negedge clk);
    we = 1'b0; ch = 2'(c); rg = 2'(r);
    #1;
    chk(rd == 16'(exp), tag, rd, exp);
  endtask

  task automatic wait_done(input int c);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_o[c]) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 4; c++) rd_chk(c, 0, 0, "R1 control after reset");
    chk(irq == 1'b0 && req == 1'b0, "R1 idle outputs", {irq, req}, 0);

    // R2 programming and readback, port->mem on channel 2
    wr(2, 1, 'h33);
    wr(2, 2, 'h0100);
    wr(2, 3, 3);
    rd_chk(2, 1, 'h33, "R2 port readback");
    rd_chk(2, 2, 'h0100, "R2 mem readback");
    rd_chk(2, 3, 3, "R2 count readback");
    wr(2, 0, 'b0111);
    wait_done(2);
    @(negedge clk);
    rd_chk(2, 2, 'h0103, "R6 mem address advanced by count");
    rd_chk(2, 3, 0, "R6 count exhausted");
    rd_chk(2, 0, 'b1110, "R7 enable cleared, done set");
    chk(irq == 1'b1, "R8 irq for masked-in done", irq, 1);

    // R3 writes to a live channel are ignored; mem->port, random grant
    gnt_mode = 1;
    wr(1, 1, 'h44);
    wr(1, 2, 'h2000);
    wr(1, 3, 20);
    wr(1, 0, 'b0001);
    wr(1, 1, 'hAA);
    rd_chk(1, 1, 'h44, "R3 port write to live channel ignored");
    wr(1, 0, 'b0000);
    chk(en_o[1] == 1'b1, "R3 disable write to live channel ignored", en_o[1], 1);
    wait_done(1);
    @(negedge clk);
    rd_chk(1, 2, 'h2014, "R6 mem address after 20 words");
    chk(irq == 1'b1, "R8 masked-off done adds nothing", irq, 1);

    // R9 clear done on channel 2 -> irq drops
    wr(2, 0, 'b1000);
    @(negedge clk);
    chk(done_o[2] == 1'b0, "R9 done cleared", done_o[2], 0);
    chk(irq == 1'b0, "R8 irq low with no masked-in done", irq, 1'b0);

    // R10 lower channel takes over mid-block
    gnt_mode = 0;
    wr(3, 2, 'h3000); wr(3, 3, 4);
    wr(0, 2, 'h0500); wr(0, 3, 2);
    wr(3, 0, 'b0101);
    wr(0, 0, 'b0111);
    wait_done(0);
    chk(en_o[3] == 1'b1, "R10 channel 0 finished before channel 3", en_o[3], 1);
    wait_done(3);
    @(negedge clk);
    rd_chk(3, 2, 'h3004, "R10 channel 3 resumed to completion");

    // R7 zero-count enable completes without bus activity
    wr(0, 0, 'b1000);
    chk(done_o[0] == 1'b0, "R9 done cleared on channel 0", done_o[0], 0);
    wr(0, 3, 0);
    wr(0, 0, 'b0001);
    @(negedge clk);
    chk(done_o[0] == 1'b1 && en_o[0] == 1'b0, "R7 zero count completes", {done_o[0], en_o[0]}, 2);
    chk(req == 1'b0, "R7 no bus request for zero count", req, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule